// File: doc/BRIEF.md
# UART FIFO Service Request and Interrupt Controller

This block sits beside the transmit and receive FIFOs of a UART and decides how each direction is serviced. A 32-bit control register, written and read over a simple register bus, routes each FIFO direction to a DMA request line or to the CPU interrupt path. The same register enables interrupts for free space in the transmit FIFO, for received data (either the receive-full level or a receive timeout), and for receive errors. It also selects which edges of the clear-to-send input are recorded.

Four sticky status flags record the events. Software clears a flag by writing 1 to its bit in the status register. A single registered interrupt output is raised while any flag is set and that flag's source is enabled. The FIFOs, serializer, baud generation and DMA engine are outside this block. It only turns their level and error flags into requests.

Top module: `uart_svc_req_ctrl`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0, and `irq`, `tx_dma_req` and `rx_dma_req` are 0.
- R2: Only control bits 15:9 can be written. Bits 31:16 and 8:0 read 0, and writes to them have no effect, so writing all ones reads back 0x0000FE00.
- R3: `tx_dma_req` is 1 exactly while control bit 15 is 1 and `tx_fifo_full` is 0. `rx_dma_req` is 1 exactly while control bit 14 is 1 and `rx_fifo_empty` is 0. Both follow their inputs in the same cycle.
- R4: The status flags are sticky and are set on the clock edge after their event. Bit 0 (tx room) is set while `tx_fifo_full` is 0. Bit 1 (rx ready) is set by `rx_data_full` or `rx_timeout`. Bit 2 (rx fault) is set by `err_frame`, `err_parity` or `err_overrun`. The status register reads 0 above bit 3.
- R5: Control bits 10:9 choose the CTS condition that sets status bit 3: 00 never, 01 a rising edge, 10 a falling edge, 11 either edge. `cts_pin` passes through two synchronizer flops and is compared with its previous value, so a change of the pin shows in bit 3 after the third rising clock edge and not after the second.
- R6: A status write clears each flag whose bit in the written data is 1 and leaves flags written with 0 unchanged. If a flag's event occurs in the same cycle as its clear, the flag stays set.
- R7: `irq` is registered. It is 1 in the cycle after at least one set flag has its source enabled. The sources are: bit 0 by control bit 13, bit 1 by control bit 12, bit 2 by control bit 11, and bit 3 by a nonzero CTS condition.
- R8: When a direction is routed to DMA, its FIFO flag cannot raise `irq`. Control bit 15 masks the tx room source and control bit 14 masks the rx ready source, even when their interrupt enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | Write target: 0 control, 1 status (write-1-to-clear) |
| reg_wdata | input | 32 | Write data |
| reg_rd_sel | input | 1 | Read target: 0 control, 1 status |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| tx_fifo_full | input | 1 | Transmit FIFO has no free entry |
| rx_fifo_empty | input | 1 | Receive FIFO holds no data |
| rx_data_full | input | 1 | Receive FIFO reached its fill level |
| rx_timeout | input | 1 | Receive timeout occurred |
| err_frame | input | 1 | Framing error on receive |
| err_parity | input | 1 | Parity error on receive |
| err_overrun | input | 1 | Overrun error on receive |
| cts_pin | input | 1 | Asynchronous clear-to-send input |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions check on every cycle that the status flags stay set between clears, that receive events always leave their flag set even when a clear arrives in the same cycle, and that the DMA lines match the routing bits and FIFO levels. They also check that `irq` follows the enabled flags one cycle later, in both directions, and that no CTS flag appears while detection is off. Only the bench scenarios can show the latency of the CTS synchronizer, that each of the four edge conditions is decoded correctly, that reserved bits are masked, and the read-back values of the register bus.

// File: rtl/uart_svc_pkg.sv
package uart_svc_pkg;

  localparam int CTRL_W      = 32;
  localparam int TX_DMA_BIT  = 15;
  localparam int RX_DMA_BIT  = 14;
  localparam int TX_IE_BIT   = 13;
  localparam int RX_IE_BIT   = 12;
  localparam int ERR_IE_BIT  = 11;
  localparam int CTS_MODE_HI = 10;
  localparam int CTS_MODE_LO = 9;
  localparam logic [CTRL_W-1:0] CTRL_WR_MASK = 32'h0000_FE00;

  localparam int ST_TX_ROOM  = 0;
  localparam int ST_RX_READY = 1;
  localparam int ST_RX_FAULT = 2;
  localparam int ST_CTS_CHG  = 3;
  localparam int ST_N        = 4;

  typedef enum logic [1:0] {
    CTS_OFF  = 2'b00,
    CTS_RISE = 2'b01,
    CTS_FALL = 2'b10,
    CTS_BOTH = 2'b11
  } cts_mode_e;

  // Does an observed edge match the programmed condition?
  function automatic logic cts_hit(input cts_mode_e mode, input logic rise, input logic fall);
    case (mode)
      CTS_RISE: cts_hit = rise;
      CTS_FALL: cts_hit = fall;
      CTS_BOTH: cts_hit = rise | fall;
      default:  cts_hit = 1'b0;
    endcase
  endfunction

  // Per-flag interrupt enables; a DMA-routed direction masks its FIFO source.
  function automatic logic [ST_N-1:0] irq_enables(input logic [CTRL_W-1:0] ctrl);
    logic [ST_N-1:0] en;
    en[ST_TX_ROOM]  = ctrl[TX_IE_BIT] & ~ctrl[TX_DMA_BIT];
    en[ST_RX_READY] = ctrl[RX_IE_BIT] & ~ctrl[RX_DMA_BIT];
    en[ST_RX_FAULT] = ctrl[ERR_IE_BIT];
    en[ST_CTS_CHG]  = |ctrl[CTS_MODE_HI:CTS_MODE_LO];
    return en;
  endfunction

endpackage

// File: rtl/cts_edge_detect.sv
module cts_edge_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[LAST];
  end

  assign rise_o = sync_q[LAST] & ~prev_q;
  assign fall_o = ~sync_q[LAST] & prev_q;
endmodule

// File: rtl/svc_ctrl_reg.sv
module svc_ctrl_reg #(
  parameter int          W    = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] ctrl_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ctrl_o <= '0;
    else if (wr_i) ctrl_o <= wdata_i & MASK;
  end
endmodule

// File: rtl/svc_status_flags.sv
module svc_status_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flags_o[i] <= 1'b0;
        else if (set_i[i]) flags_o[i] <= 1'b1;   // event beats clear
        else if (clr_i[i]) flags_o[i] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/uart_svc_req_ctrl.sv
module uart_svc_req_ctrl
  import uart_svc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_wr_sel,
  input  logic [31:0] reg_wdata,
  input  logic        reg_rd_sel,
  output logic [31:0] reg_rdata,
  input  logic        tx_fifo_full,
  input  logic        rx_fifo_empty,
  input  logic        rx_data_full,
  input  logic        rx_timeout,
  input  logic        err_frame,
  input  logic        err_parity,
  input  logic        err_overrun,
  input  logic        cts_pin,
  output logic        tx_dma_req,
  output logic        rx_dma_req,
  output logic        irq
);
  localparam int PAD_W = CTRL_W - ST_N;

  logic [CTRL_W-1:0] ctrl_q;
  logic [ST_N-1:0]   status_q;
  logic [ST_N-1:0]   flag_set;
  logic [ST_N-1:0]   flag_clr;
  logic              cts_rise;
  logic              cts_fall;
  logic              cts_event;
  logic              irq_q;
  cts_mode_e         cts_mode;

  svc_ctrl_reg #(.W(CTRL_W), .MASK(CTRL_WR_MASK)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (reg_wr & ~reg_wr_sel),
    .wdata_i(reg_wdata),
    .ctrl_o (ctrl_q)
  );

  cts_edge_detect #(.STAGES(SYNC_STAGES)) u_cts (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (cts_pin),
    .rise_o(cts_rise),
    .fall_o(cts_fall)
  );

  assign cts_mode  = cts_mode_e'(ctrl_q[CTS_MODE_HI:CTS_MODE_LO]);
  assign cts_event = cts_hit(cts_mode, cts_rise, cts_fall);

  always_comb begin
    flag_set              = '0;
    flag_set[ST_TX_ROOM]  = ~tx_fifo_full;
    flag_set[ST_RX_READY] = rx_data_full | rx_timeout;
    flag_set[ST_RX_FAULT] = err_frame | err_parity | err_overrun;
    flag_set[ST_CTS_CHG]  = cts_event;
  end

  assign flag_clr = (reg_wr && reg_wr_sel) ? reg_wdata[ST_N-1:0] : '0;

  svc_status_flags #(.N(ST_N)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (flag_set),
    .clr_i  (flag_clr),
    .flags_o(status_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(status_q & irq_enables(ctrl_q));
  end

  assign irq        = irq_q;
  assign tx_dma_req = ctrl_q[TX_DMA_BIT] & ~tx_fifo_full;
  assign rx_dma_req = ctrl_q[RX_DMA_BIT] & ~rx_fifo_empty;
  assign reg_rdata  = reg_rd_sel ? {{PAD_W{1'b0}}, status_q} : ctrl_q;
endmodule

// File: rtl/uart_svc_req_ctrl_checker.sv
module uart_svc_req_ctrl_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        reg_wr_sel,
  input logic        tx_fifo_full,
  input logic        rx_fifo_empty,
  input logic        rx_timeout,
  input logic        err_frame,
  input logic        err_parity,
  input logic        err_overrun,
  input logic        tx_dma_req,
  input logic        rx_dma_req,
  input logic        irq,
  input logic [31:0] ctrl_q,
  input logic [3:0]  status_q
);
  logic [3:0] live_en;
  assign live_en = {ctrl_q[10] | ctrl_q[9],
                    ctrl_q[11],
                    ctrl_q[12] && !ctrl_q[14],
                    ctrl_q[13] && !ctrl_q[15]};

  assert_tx_dma_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dma_req == (ctrl_q[15] && !tx_fifo_full));
  assert_rx_dma_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dma_req == (ctrl_q[14] && !rx_fifo_empty));
  assert_fault_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_frame || err_parity || err_overrun) |=> status_q[2]);
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_wr_sel) |=> ((status_q & $past(status_q)) == $past(status_q)));
  assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_timeout |=> status_q[1]);
  assert_cts_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[10:9] == 2'b00 && !status_q[3]) |=> !status_q[3]);
  assert_irq_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & live_en) != 4'd0) |=> irq);
  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & live_en) == 4'd0) |=> !irq);
  assert_dma_masks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[15] && ctrl_q[14] && !ctrl_q[11] && ctrl_q[10:9] == 2'b00) |=> !irq);
endmodule

bind uart_svc_req_ctrl uart_svc_req_ctrl_checker u_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr       (reg_wr),
  .reg_wr_sel   (reg_wr_sel),
  .tx_fifo_full (tx_fifo_full),
  .rx_fifo_empty(rx_fifo_empty),
  .rx_timeout   (rx_timeout),
  .err_frame    (err_frame),
  .err_parity   (err_parity),
  .err_overrun  (err_overrun),
  .tx_dma_req   (tx_dma_req),
  .rx_dma_req   (rx_dma_req),
  .irq          (irq),
  .ctrl_q       (ctrl_q),
  .status_q     (status_q)
);

// File: tb/uart_svc_req_ctrl_test.sv
`timescale 1ns/1ps
module uart_svc_req_ctrl_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_wr_sel, reg_rd_sel;
  logic [31:0] reg_wdata, reg_rdata;
  logic        tx_fifo_full, rx_fifo_empty, rx_data_full, rx_timeout;
  logic        err_frame, err_parity, err_overrun, cts_pin;
  logic        tx_dma_req, rx_dma_req, irq;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_svc_req_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wr_sel(reg_wr_sel),
    .reg_wdata(reg_wdata), .reg_rd_sel(reg_rd_sel), .reg_rdata(reg_rdata),
    .tx_fifo_full(tx_fifo_full), .rx_fifo_empty(rx_fifo_empty),
    .rx_data_full(rx_data_full), .rx_timeout(rx_timeout),
    .err_frame(err_frame), .err_parity(err_parity), .err_overrun(err_overrun),
    .cts_pin(cts_pin), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req), .irq(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] data);
    reg_wr = 1'b1; reg_wr_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] data);
    reg_rd_sel = sel;
    #1;
    data = reg_rdata;
  endtask

  task automatic clear_all();
    wr(1'b1, 32'hF);
  endtask

  task automatic test_reset();
    logic [31:0] v;
    rd(1'b0, v); chk("R1 control after reset", v, 32'h0);
    rd(1'b1, v); chk("R1 status after reset", v, 32'h0);
    chk("R1 irq after reset", {31'd0, irq}, 32'h0);
    chk("R1 dma lines after reset", {30'd0, tx_dma_req, rx_dma_req}, 32'h0);
  endtask

  task automatic test_reserved();
    logic [31:0] v;
    wr(1'b0, 32'hFFFF_FFFF);
    rd(1'b0, v); chk("R2 all-ones write masks reserved bits", v, 32'h0000_FE00);
    wr(1'b0, 32'hFFFF_01FF);
    rd(1'b0, v); chk("R2 reserved-only write has no effect", v, 32'h0);
    clear_all();
  endtask

  task automatic test_dma();
    wr(1'b0, 32'h0000_C000);
    tx_fifo_full = 1'b0; rx_fifo_empty = 1'b0; #1;
    chk("R3 tx request with room", {31'd0, tx_dma_req}, 32'h1);
    chk("R3 rx request with data", {31'd0, rx_dma_req}, 32'h1);
    tx_fifo_full = 1'b1; rx_fifo_empty = 1'b1; #1;
    chk("R3 tx request drops when full", {31'd0, tx_dma_req}, 32'h0);
    chk("R3 rx request drops when empty", {31'd0, rx_dma_req}, 32'h0);
    wr(1'b0, 32'h0);
    tx_fifo_full = 1'b0; rx_fifo_empty = 1'b0; #1;
    chk("R3 no requests while routed to cpu", {30'd0, tx_dma_req, rx_dma_req}, 32'h0);
    tx_fifo_full = 1'b1; rx_fifo_empty = 1'b1;
    clear_all();
  endtask

  task automatic test_sticky();
    logic [31:0] v;
    rx_timeout = 1'b1; tick(1); rx_timeout = 1'b0; tick(2);
    rd(1'b1, v); chk("R4 timeout sets rx ready", v, 32'h2);
    clear_all();
    rx_data_full = 1'b1; tick(1); rx_data_full = 1'b0; tick(1);
    rd(1'b1, v); chk("R4 data full sets rx ready", v, 32'h2);
    clear_all();
    err_parity = 1'b1; tick(1); err_parity = 1'b0; tick(2);
    rd(1'b1, v); chk("R4 parity error sets fault", v, 32'h4);
    clear_all();
    err_frame = 1'b1; tick(1); err_frame = 1'b0; tick(1);
    rd(1'b1, v); chk("R4 framing error sets fault", v, 32'h4);
    clear_all();
    tx_fifo_full = 1'b0; tick(1); tx_fifo_full = 1'b1; tick(1);
    rd(1'b1, v); chk("R4 free tx space sets tx room", v, 32'h1);
    clear_all();
  endtask

  task automatic test_clear();
    logic [31:0] v;
    rx_timeout = 1'b1; err_overrun = 1'b1; tick(1);
    rx_timeout = 1'b0; err_overrun = 1'b0;
    wr(1'b1, 32'h0);
    rd(1'b1, v); chk("R6 writing zero keeps flags", v, 32'h6);
    wr(1'b1, 32'h2);
    rd(1'b1, v); chk("R6 write one clears only its flag", v, 32'h4);
    rx_timeout = 1'b1;
    wr(1'b1, 32'h2);
    rx_timeout = 1'b0;
    rd(1'b1, v); chk("R6 event in clear cycle wins", v, 32'h6);
    clear_all();
    rd(1'b1, v); chk("R6 clear all flags", v, 32'h0);
  endtask

  task automatic test_cts();
    logic [31:0] v;
    wr(1'b0, 32'h0000_0200);
    clear_all();
    cts_pin = 1'b1; tick(2);
    rd(1'b1, v); chk("R5 no flag after two edges", v & 32'h8, 32'h0);
    tick(1);
    rd(1'b1, v); chk("R5 flag after third edge", v & 32'h8, 32'h8);
    cts_pin = 1'b0; tick(4);
    for (int m = 0; m < 4; m++) begin
      wr(1'b0, 32'(m) << 9);
      clear_all();
      cts_pin = 1'b1; tick(4);
      rd(1'b1, v); chk($sformatf("R5 mode %0d rising", m), v & 32'h8, (m & 1) ? 32'h8 : 32'h0);
      clear_all();
      cts_pin = 1'b0; tick(4);
      rd(1'b1, v); chk($sformatf("R5 mode %0d falling", m), v & 32'h8, (m & 2) ? 32'h8 : 32'h0);
    end
    wr(1'b0, 32'h0);
    clear_all();
  endtask

  task automatic test_irq();
    wr(1'b0, 32'h0000_0800);
    err_overrun = 1'b1; tick(1); err_overrun = 1'b0;
    chk("R7 irq one cycle behind flag", {31'd0, irq}, 32'h0);
    tick(1);
    chk("R7 irq from rx fault", {31'd0, irq}, 32'h1);
    wr(1'b1, 32'h4);
    chk("R7 irq still set on clear edge", {31'd0, irq}, 32'h1);
    tick(1);
    chk("R7 irq drops after clear", {31'd0, irq}, 32'h0);
    wr(1'b0, 32'h0000_2000);
    tx_fifo_full = 1'b0; tick(2);
    chk("R7 irq from tx room", {31'd0, irq}, 32'h1);
    tx_fifo_full = 1'b1; clear_all(); tick(1);
    chk("R7 irq off after tx room cleared", {31'd0, irq}, 32'h0);
    wr(1'b0, 32'h0000_0200);
    clear_all();
    cts_pin = 1'b1; tick(4);
    chk("R7 irq from cts change", {31'd0, irq}, 32'h1);
    cts_pin = 1'b0; tick(4);
    wr(1'b0, 32'h0); clear_all(); tick(1);
  endtask

  task automatic test_mask();
    wr(1'b0, 32'h0000_A000);
    clear_all();
    tx_fifo_full = 1'b0; tick(2);
    chk("R8 tx dma masks tx room irq", {31'd0, irq}, 32'h0);
    chk("R8 tx dma request active", {31'd0, tx_dma_req}, 32'h1);
    tx_fifo_full = 1'b1;
    wr(1'b0, 32'h0000_5000);
    clear_all();
    rx_timeout = 1'b1; tick(1); rx_timeout = 1'b0; tick(2);
    chk("R8 rx dma masks rx ready irq", {31'd0, irq}, 32'h0);
    wr(1'b0, 32'h0000_1000); tick(1);
    chk("R8 irq once rx routed to cpu", {31'd0, irq}, 32'h1);
    wr(1'b0, 32'h0); clear_all();
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_wr_sel = 1'b0; reg_wdata = '0; reg_rd_sel = 1'b0;
    tx_fifo_full = 1'b1; rx_fifo_empty = 1'b1; rx_data_full = 1'b0; rx_timeout = 1'b0;
    err_frame = 1'b0; err_parity = 1'b0; err_overrun = 1'b0; cts_pin = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    test_reset();
    test_reserved();
    test_dma();
    test_sticky();
    test_clear();
    test_cts();
    test_irq();
    test_mask();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule